// File: doc/BRIEF.md
# SDRAM Open-Row Tracking Command Scheduler

This block sits between a single requester and a four-bank SDRAM. It holds one entry per bank, a valid flag and the address of the row that is open there, so up to four rows can be open at the same time. Each accepted access falls into one of three classes:
- a row hit, which goes straight to the column command;
- an access to a bank with no open row, which needs an ACTIVATE first;
- a conflict with a different open row in the same bank, which needs a PRECHARGE and then an ACTIVATE.

The gaps after PRECHARGE and after ACTIVATE are cycle counts taken from input ports. Read data is flagged after a CAS latency of two or three cycles.

A requester presents bank, row, column, direction and write data. It holds them until the grant, which comes in the same cycle whenever the scheduler is idle. Hits to open rows in any bank can be granted on every clock, so a stream moves one 16-bit word per cycle and pays the row-open cost only on a real miss. A close-all input empties the table, as a refresh sequencer would need. Two saturating counters give the number of hits and misses, so the data layout across banks can be judged.

Top module: `sdram_rowtrack_ctrl`

## Requirements
- R1: After reset `sd_cmd` is NOP (code 0), `req_grant` is low while no request is presented, both counters read zero, and every bank is treated as having no open row.
- R2: A request is granted in the cycle it is presented if the scheduler is idle and `close_all` is low. Row hits presented back to back are granted on every clock.
- R3: An accepted row hit puts the column command on `sd_cmd` in the next cycle, with no PRECHARGE or ACTIVATE: READ is code 3 and WRITE is code 4.
- R4: An access to a bank with no open row issues ACTIVATE (code 1) in the next cycle, with the row on `sd_addr`. The column command follows exactly `t_rcd` cycles after the ACTIVATE, and a value of 0 counts as 1.
- R5: An access that conflicts with a different open row in the same bank issues PRECHARGE (code 2) to that bank in the next cycle. ACTIVATE follows exactly `t_rp` cycles later (0 counts as 1), and the column command follows `t_rcd` cycles after that.
- R6: Each of the four banks keeps its own open row, so opening a row in one bank leaves the rows open in the others unchanged. A bank holds only one open row, and the last one opened replaces the one before.
- R7: While `close_all` is high no request is granted. Afterwards every bank counts as closed, so the next access to a bank issues ACTIVATE without a PRECHARGE.
- R8: `rd_valid` goes high exactly 2 cycles after a READ command when `cas_sel` is 0, and exactly 3 cycles after it when `cas_sel` is 1. In that cycle `rd_data` equals `sd_rdata`.
- R9: `hit_count` goes up by one for each accepted hit. `miss_count` goes up by one for each accepted access to a closed bank or to a conflicting row. Both counters hold at all ones.
- R10: With a column command, `sd_bank` carries the bank and the low bits of `sd_addr` carry the column, with zeros above them. A WRITE carries the request's data on `sd_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| close_all | input | 1 | Marks every bank closed, blocks grants |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the access |
| req_row | input | 13 | Row of the access |
| req_col | input | 9 | Column of the access |
| req_wdata | input | 16 | Write data |
| req_grant | output | 1 | Request accepted this cycle |
| t_rp | input | 4 | PRECHARGE-to-ACTIVATE gap in cycles |
| t_rcd | input | 4 | ACTIVATE-to-column gap in cycles |
| cas_sel | input | 1 | 0 = CAS latency 2, 1 = CAS latency 3 |
| sd_cmd | output | 3 | Command: 0 NOP, 1 ACT, 2 PRE, 3 READ, 4 WRITE |
| sd_bank | output | 2 | Bank of the command |
| sd_addr | output | 13 | Row for ACT, column for READ/WRITE |
| sd_wdata | output | 16 | Data sent with WRITE |
| sd_rdata | input | 16 | Data returned by the memory |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| hit_count | output | 16 | Saturating row-hit count |
| miss_count | output | 16 | Saturating miss count |

## Verification
The gap assertions assume that `t_rp`, `t_rcd` and `cas_sel` stay constant while a command sequence is in flight. The latency checks also assume that `cas_sel` does not change between a READ and its data. The bench changes these settings only after the scheduler has been idle for many cycles. It holds every request until granted and raises `close_all` only when no sequence is pending, so the table is never cleared halfway through a miss.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ACC_HIT,
    ACC_EMPTY,
    ACC_CONFLICT
  } acc_kind_e;

  // Classifies an access from the table lookup of its bank.
  function automatic acc_kind_e classify(input logic bank_open, input logic row_same);
    if (!bank_open)    return ACC_EMPTY;
    else if (row_same) return ACC_HIT;
    else               return ACC_CONFLICT;
  endfunction

  function automatic logic is_column(input sd_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sdrt_bank_table.sv
module sdrt_bank_table #(
  parameter int BANK_BITS = 2,
  parameter int ROW_W     = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_all,
  input  logic [BANK_BITS-1:0] look_bank,
  input  logic [ROW_W-1:0]     look_row,
  output logic                 look_open,
  output logic                 look_same,
  input  logic                 upd_en,
  input  logic [BANK_BITS-1:0] upd_bank,
  input  logic [ROW_W-1:0]     upd_row,
  output logic [(1<<BANK_BITS)-1:0] open_vec
);
  localparam int NB = 1 << BANK_BITS;

  logic [ROW_W-1:0] row_arr [NB];

  for (genvar g = 0; g < NB; g++) begin : g_entry
    logic             vld_q;
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        row_q <= '0;
      end else if (clear_all) begin
        vld_q <= 1'b0;
      end else if (upd_en && (upd_bank == BANK_BITS'(g))) begin
        vld_q <= 1'b1;
        row_q <= upd_row;
      end
    end
    assign open_vec[g] = vld_q;
    assign row_arr[g]  = row_q;
  end

  assign look_open = open_vec[look_bank];
  assign look_same = (row_arr[look_bank] == look_row);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (open_vec == '0)); // R7
  AST_UPDATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clear_all) |=> open_vec[$past(upd_bank)]); // R6

endmodule

// File: rtl/sdrt_read_pipe.sv
module sdrt_read_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic cas_sel,
  output logic valid
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[1:0], issue};
  end

  assign valid = cas_sel ? pipe_q[2] : pipe_q[1];

  AST_CL2_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_sel && valid) |-> $past(issue, 2)); // R8
  AST_CL3_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_sel && valid) |-> $past(issue, 3)); // R8

endmodule

// File: rtl/sdrt_sat_counter.sv
module sdrt_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= bump(count);
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP)); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |=> (count != '0)); // R9

endmodule

// File: rtl/sdram_rowtrack_ctrl.sv
module sdram_rowtrack_ctrl
  import sdrt_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int DLY_W     = 4,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 close_all,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [BANK_BITS-1:0] req_bank,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 req_grant,
  input  logic [DLY_W-1:0]     t_rp,
  input  logic [DLY_W-1:0]     t_rcd,
  input  logic                 cas_sel,
  output logic [2:0]           sd_cmd,
  output logic [BANK_BITS-1:0] sd_bank,
  output logic [ROW_W-1:0]     sd_addr,
  output logic [DATA_W-1:0]    sd_wdata,
  input  logic [DATA_W-1:0]    sd_rdata,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic [CNT_W-1:0]     hit_count,
  output logic [CNT_W-1:0]     miss_count
);
  localparam int NB    = 1 << BANK_BITS;
  localparam int GAP_W = DLY_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE_WAIT, ST_ACT_WAIT} state_e;

  function automatic logic [ROW_W-1:0] col_addr(input logic [COL_W-1:0] c);
    return ROW_W'(c);
  endfunction

  // A programmed gap of 0 behaves as 1.
  function automatic logic [GAP_W-1:0] eff_gap(input logic [DLY_W-1:0] t);
    return (t == '0) ? GAP_W'(1) : GAP_W'(t);
  endfunction

  state_e                 state_q;
  sd_cmd_e                cmd_q;
  logic [DLY_W-1:0]       wait_q;
  logic                   p_write;
  logic [BANK_BITS-1:0]   p_bank;
  logic [ROW_W-1:0]       p_row;
  logic [COL_W-1:0]       p_col;
  logic [DATA_W-1:0]      p_wdata;
  logic                   bank_open, row_same;
  logic [NB-1:0]          open_vec;
  acc_kind_e              kind;

  // Named internal events
  logic accept, acc_hit, acc_miss, wait_over;

  assign accept    = (state_q == ST_IDLE) && req_valid && !close_all;
  assign kind      = classify(bank_open, row_same);
  assign acc_hit   = accept && (kind == ACC_HIT);
  assign acc_miss  = accept && (kind != ACC_HIT);
  assign wait_over = (wait_q <= DLY_W'(1));
  assign req_grant = accept;

  sdrt_bank_table #(.BANK_BITS(BANK_BITS), .ROW_W(ROW_W)) u_table (
    .clk, .rst_n,
    .clear_all (close_all),
    .look_bank (req_bank),
    .look_row  (req_row),
    .look_open (bank_open),
    .look_same (row_same),
    .upd_en    (acc_miss),
    .upd_bank  (req_bank),
    .upd_row   (req_row),
    .open_vec  (open_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      wait_q   <= '0;
      sd_bank  <= '0;
      sd_addr  <= '0;
      sd_wdata <= '0;
      p_write  <= 1'b0;
      p_bank   <= '0;
      p_row    <= '0;
      p_col    <= '0;
      p_wdata  <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          p_write <= req_write;
          p_bank  <= req_bank;
          p_row   <= req_row;
          p_col   <= req_col;
          p_wdata <= req_wdata;
          sd_bank <= req_bank;
          unique case (kind)
            ACC_HIT: begin
              cmd_q    <= req_write ? CMD_WR : CMD_RD;
              sd_addr  <= col_addr(req_col);
              sd_wdata <= req_wdata;
            end
            ACC_EMPTY: begin
              cmd_q   <= CMD_ACT;
              sd_addr <= req_row;
              wait_q  <= t_rcd;
              state_q <= ST_ACT_WAIT;
            end
            default: begin
              cmd_q   <= CMD_PRE;
              sd_addr <= '0;
              wait_q  <= t_rp;
              state_q <= ST_PRE_WAIT;
            end
          endcase
        end
        ST_PRE_WAIT: if (wait_over) begin
          cmd_q   <= CMD_ACT;
          sd_addr <= p_row;
          wait_q  <= t_rcd;
          state_q <= ST_ACT_WAIT;
        end else begin
          wait_q <= wait_q - 1'b1;
        end
        default: if (wait_over) begin
          cmd_q    <= p_write ? CMD_WR : CMD_RD;
          sd_addr  <= col_addr(p_col);
          sd_wdata <= p_wdata;
          state_q  <= ST_IDLE;
        end else begin
          wait_q <= wait_q - 1'b1;
        end
      endcase
    end
  end

  assign sd_cmd  = cmd_q;
  assign rd_data = sd_rdata;

  sdrt_read_pipe u_rdpipe (
    .clk, .rst_n,
    .issue   (cmd_q == CMD_RD),
    .cas_sel (cas_sel),
    .valid   (rd_valid)
  );

  sdrt_sat_counter #(.W(CNT_W)) u_hits (
    .clk, .rst_n, .inc(acc_hit), .count(hit_count)
  );
  sdrt_sat_counter #(.W(CNT_W)) u_misses (
    .clk, .rst_n, .inc(acc_miss), .count(miss_count)
  );

  // Assertion support: cycles since the last ACT and the last PRE, and the
  // last command other than NOP.
  logic [GAP_W-1:0] since_act_q, since_pre_q;
  sd_cmd_e          last_cmd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act_q <= '1;
      since_pre_q <= '1;
      last_cmd_q  <= CMD_NOP;
    end else begin
      since_act_q <= (cmd_q == CMD_ACT) ? GAP_W'(1) :
                     (since_act_q == '1) ? since_act_q : since_act_q + 1'b1;
      since_pre_q <= (cmd_q == CMD_PRE) ? GAP_W'(1) :
                     (since_pre_q == '1) ? since_pre_q : since_pre_q + 1'b1;
      if (cmd_q != CMD_NOP) last_cmd_q <= cmd_q;
    end
  end

  AST_HIT_GOES_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> is_column(cmd_q)); // R3
  AST_EMPTY_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_miss && !bank_open) |=> (cmd_q == CMD_ACT)); // R4
  AST_CONFLICT_PRECHARGES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_miss && bank_open) |=> (cmd_q == CMD_PRE)); // R5
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_column(cmd_q) && last_cmd_q == CMD_ACT) |-> (since_act_q >= eff_gap(t_rcd))); // R4
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT && last_cmd_q == CMD_PRE) |-> (since_pre_q >= eff_gap(t_rp))); // R5
  AST_NO_GRANT_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |-> !req_grant); // R7

endmodule

// File: tb/sdram_rowtrack_ctrl_tb.sv
module sdram_rowtrack_ctrl_tb;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n, close_all, req_valid, req_write, cas_sel;
  logic [1:0]  req_bank;
  logic [12:0] req_row;
  logic [8:0]  req_col;
  logic [15:0] req_wdata, sd_rdata;
  logic [3:0]  t_rp, t_rcd;
  logic        req_grant, rd_valid;
  logic [2:0]  sd_cmd;
  logic [1:0]  sd_bank;
  logic [12:0] sd_addr;
  logic [15:0] sd_wdata, rd_data;
  logic [CW-1:0] hit_count, miss_count;

  int total = 0, bad = 0;
  int exp_hits = 0, exp_miss = 0;
  logic [15:0] cyc = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1'b1;
  assign sd_rdata = cyc ^ 16'h5A00;

  sdram_rowtrack_ctrl #(.CNT_W(CW)) u_dut (
    .clk, .rst_n, .close_all, .req_valid, .req_write, .req_bank, .req_row,
    .req_col, .req_wdata, .req_grant, .t_rp, .t_rcd, .cas_sel, .sd_cmd,
    .sd_bank, .sd_addr, .sd_wdata, .sd_rdata, .rd_valid, .rd_data,
    .hit_count, .miss_count
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // kind: 0 hit, 1 closed bank, 2 conflict. Starts and ends at a negedge.
  task automatic run_acc(input string tag, input logic wr, input logic [1:0] b,
                         input logic [12:0] r, input logic [8:0] c,
                         input logic [15:0] d, input int kind);
    int rp   = (t_rp  == 0) ? 1 : int'(t_rp);
    int rcd  = (t_rcd == 0) ? 1 : int'(t_rcd);
    int cl   = cas_sel ? 3 : 2;
    int col_i = (kind == 0) ? 0 : (kind == 1) ? rcd : rp + rcd;
    int act_i = (kind == 2) ? rp : 0;
    int err_i = -1, err_a = 0, err_e = 0;
    int rv_seen = -1;
    req_valid = 1'b1; req_write = wr; req_bank = b; req_row = r;
    req_col = c; req_wdata = d;
    #1;
    chk(req_grant === 1'b1, "R2", "grant on idle request", int'(req_grant), 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin
      int e = 0;
      if (i == col_i) e = wr ? 4 : 3;
      else if (kind == 2 && i == 0) e = 2;
      else if (kind != 0 && i == act_i) e = 1;
      if (err_i < 0 && sd_cmd !== 3'(e)) begin err_i = i; err_a = sd_cmd; err_e = e; end
      if (err_i < 0 && kind != 0 && i == act_i && sd_addr !== r) begin
        err_i = i; err_a = sd_addr; err_e = r;
      end
      if (err_i < 0 && i == col_i &&
          (sd_addr !== 13'(c) || sd_bank !== b || (wr && sd_wdata !== d))) begin
        err_i = i; err_a = sd_addr; err_e = c;
      end
      if (rd_valid === 1'b1 && rv_seen < 0) begin
        rv_seen = i;
        chk(rd_data === sd_rdata, "R8", "read data passes through", rd_data, sd_rdata);
      end
      @(negedge clk);
    end
    chk(err_i < 0, tag, $sformatf("command trace (kind %0d) at cycle %0d", kind, err_i),
        err_a, err_e);
    if (!wr)
      chk(rv_seen == col_i + cl, "R8", "read valid cycle", rv_seen, col_i + cl);
    else
      chk(rv_seen < 0, "R8", "no read valid on write", rv_seen, -1);
    if (kind == 0) exp_hits++; else exp_miss++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sd_cmd === 3'd0, "R1", "cmd after reset", sd_cmd, 0);
    chk(req_grant === 1'b0, "R1", "no grant without request", req_grant, 0);
    chk(hit_count === '0 && miss_count === '0, "R1", "counters zero",
        hit_count + miss_count, 0);
  endtask

  task automatic t_stream();
    req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd0; req_row = 13'd5;
    req_col = 9'h020;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(req_grant === 1'b1, "R2", "back-to-back hit grant", req_grant, 1);
      @(negedge clk);
      chk(sd_cmd === 3'd3 && sd_addr === 13'(9'h020 + k), "R3",
          "streaming column", sd_addr, 9'h020 + k);
      if (k < 3) req_col = 9'(9'h021 + k);
      else req_valid = 1'b0;
    end
    exp_hits += 4;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_close();
    req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd2; req_row = 13'd100;
    req_col = 9'd1; close_all = 1'b1;
    #1;
    chk(req_grant === 1'b0, "R7", "grant blocked by close_all", req_grant, 0);
    @(negedge clk);
    chk(sd_cmd === 3'd0, "R7", "no command while closed", sd_cmd, 0);
    close_all = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    run_acc("R7", 1'b0, 2'd2, 13'd100, 9'd1, 16'h0, 1);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; close_all = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0; req_wdata = '0;
    t_rp = 4'd2; t_rcd = 4'd3; cas_sel = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // R4: first access after reset finds bank 0 closed
    run_acc("R4", 1'b0, 2'd0, 13'd5, 9'h010, 16'h0, 1);
    // R3/R10: write hit
    run_acc("R3", 1'b1, 2'd0, 13'd5, 9'h011, 16'hBEEF, 0);
    t_stream();
    // R6: open a row in each other bank, then hit all four
    run_acc("R6", 1'b0, 2'd1, 13'd7, 9'h030, 16'h0, 1);
    run_acc("R6", 1'b1, 2'd2, 13'd8, 9'h031, 16'h1234, 1);
    run_acc("R6", 1'b0, 2'd3, 13'd9, 9'h032, 16'h0, 1);
    run_acc("R6", 1'b0, 2'd1, 13'd7, 9'h040, 16'h0, 0);
    run_acc("R10", 1'b1, 2'd2, 13'd8, 9'h1FF, 16'hA5C3, 0);
    run_acc("R6", 1'b0, 2'd3, 13'd9, 9'h042, 16'h0, 0);
    run_acc("R6", 1'b0, 2'd0, 13'd5, 9'h043, 16'h0, 0);
    // R5: conflict with new timing, CAS latency 2
    t_rp = 4'd4; t_rcd = 4'd1; cas_sel = 1'b0;
    repeat (4) @(negedge clk);
    run_acc("R5", 1'b1, 2'd2, 13'd100, 9'h005, 16'h0F0F, 2);
    run_acc("R8", 1'b0, 2'd2, 13'd100, 9'h006, 16'h0, 0);
    run_acc("R6", 1'b0, 2'd1, 13'd7, 9'h007, 16'h0, 0);
    // R5: zero gaps behave as one cycle
    t_rp = 4'd0; t_rcd = 4'd0;
    repeat (4) @(negedge clk);
    run_acc("R5", 1'b0, 2'd2, 13'd200, 9'h008, 16'h0, 2);
    t_rp = 4'd2; t_rcd = 4'd2; cas_sel = 1'b1;
    repeat (4) @(negedge clk);
    t_close();
    run_acc("R7", 1'b0, 2'd3, 13'd9, 9'h009, 16'h0, 1);
    run_acc("R9", 1'b0, 2'd1, 13'd3, 9'h00A, 16'h0, 1);
    chk(int'(hit_count) == sat(exp_hits), "R9", "hit counter saturated",
        hit_count, sat(exp_hits));
    chk(int'(miss_count) == sat(exp_miss), "R9", "miss counter saturated",
        miss_count, sat(exp_miss));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule